// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

A bank of hardware instruction breakpoints. Each breakpoint holds a 32-bit control word and a 64-bit value word, and compares the address and execution context of each fetch against them. When a fetch is presented with `fetch_valid_i` high, the unit reports which breakpoints fire on the registered vector `hit_o`, one bit for each breakpoint, one clock later.

A breakpoint can match on an instruction address (equal or not equal), on the first-level context ID, on the second-level context ID, on the VMID, or on a combination of these. An address breakpoint can be tied to a context breakpoint chosen by a 4-bit index. It then fires only when both conditions hold, which restricts a code breakpoint to one process or one guest. The not-equal address mode is the usual way to single-step: every fetch except the stepped instruction fires. No privilege or security-state filter is applied, so every fetch qualifies.

The control and value words come in as flat static inputs. Breakpoint `i` uses `ctrl_i[32*i +: 32]` and `value_i[64*i +: 64]`.

Top module: `insn_bkpt_unit`

## Requirements
- R1: `hit_o` is all zero while `rst_ni` is low. Each bit of `hit_o` is the result for the fetch presented in the previous cycle. `hit_o` is all zero in the cycle after `fetch_valid_i` is low.
- R2: A breakpoint whose control bit 0 (enable) is 0 never fires, whatever its other fields hold.
- R3: Control word layout: bit 0 is the enable, bits 8:5 are the halfword select, bits 19:16 are the link index, bit 20 is the link flag and bits 23:21 are the kind. The kinds are 000 address equal, 001 and 011 first-level context ID, 010 address not-equal, 100 VMID, 101 VMID plus first-level context ID, 110 second-level context ID, and 111 both context IDs. All other control bits are ignored.
- R4: Address equal fires when fetch address bits 63:2 equal value bits 63:2 and one of these holds: the select is 0011 and fetch bit 1 is 0; the select is 1100 and fetch bit 1 is 1; or the select is 1111 and fetch bit 1 is 0. Address bits 1:0 of the value and bit 0 of the fetch take no part in the comparison.
- R5: Address not-equal with select 0011, 1100 or 1111 fires exactly when the R4 condition for that select is false. With select 0000 it fires on every fetch.
- R6: An address breakpoint whose select value is not listed for its kind in R4 or R5 never fires.
- R7: Value word layout: first-level context ID in bits 31:0, VMID in bits 47:32, second-level context ID in bits 63:32. Each context kind fires when every field it names equals the current `ctx1_i`, `vmid_i` or `ctx2_i`. The select field is ignored for these kinds.
- R8: A context breakpoint with its link flag set never fires on its own. It only serves as a link target.
- R9: An address breakpoint with its link flag set fires only when its address condition holds and the breakpoint named by its link index is enabled, is of a context kind and matches the current context.
- R10: A linked address breakpoint whose link index names an unimplemented breakpoint, a disabled one or one of an address kind never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32*NUM_BKPT | Control words, breakpoint i in bits 32*i+31:32*i |
| value_i | input | 64*NUM_BKPT | Value words, breakpoint i in bits 64*i+63:64*i |
| fetch_valid_i | input | 1 | A fetch is presented this cycle |
| fetch_addr_i | input | 64 | Fetch address |
| ctx1_i | input | 32 | Current first-level context ID |
| ctx2_i | input | 32 | Current second-level context ID |
| vmid_i | input | 16 | Current VMID |
| hit_o | output | NUM_BKPT | Registered hit vector |

## Verification
Every result is due exactly one clock after its fetch: the one output register is the only stage. The bench drives a fetch on a falling edge and computes the expected vector from its model at that moment. It compares `hit_o` on the next falling edge, after the single capturing rising edge, so each comparison belongs to exactly one fetch and to the control words applied with it. Directed phases cover each kind, select value and link corner. A randomized phase reprograms all breakpoints and compares every cycle.

// File: rtl/ibu_pkg.sv
package ibu_pkg;
  localparam int CW_W    = 32;
  localparam int CTX_W   = 32;
  localparam int VMID_W  = 16;
  localparam int VAL_W   = 2 * CTX_W;
  localparam int LBN_W   = 4;
  localparam int LINK_SPAN = 1 << LBN_W;

  typedef enum logic [2:0] {
    K_ADDR  = 3'd0,
    K_CTX   = 3'd1,
    K_MISS  = 3'd2,
    K_CTX1  = 3'd3,
    K_VMID  = 3'd4,
    K_VMCTX = 3'd5,
    K_CTX2  = 3'd6,
    K_FULL  = 3'd7
  } kind_e;

  typedef struct packed {
    logic             en;
    logic [3:0]       sel;
    logic [LBN_W-1:0] lbn;
    logic             linked;
    kind_e            kind;
  } bctl_t;

  function automatic bctl_t decode_ctl(logic [CW_W-1:0] w);
    bctl_t c;
    c.en     = w[0];
    c.sel    = w[8:5];
    c.lbn    = w[19:16];
    c.linked = w[20];
    c.kind   = kind_e'(w[23:21]);
    return c;
  endfunction

  function automatic logic is_addr_kind(kind_e k);
    return (k == K_ADDR) || (k == K_MISS);
  endfunction
endpackage

// File: rtl/ibu_addr_cmp.sv
module ibu_addr_cmp
  import ibu_pkg::*;
#(
  parameter int AW = VAL_W
) (
  input  kind_e         kind_i,
  input  logic [3:0]    sel_i,
  input  logic [AW-1:0] val_i,
  input  logic [AW-1:0] fetch_i,
  output logic          cond_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'(3);

  logic word_eq, hw_hi, sel_legal, sel_hit;

  assign word_eq = ((val_i ^ fetch_i) & ~LOW_MASK) == '0;
  assign hw_hi   = fetch_i[1];

  always_comb begin
    sel_legal = 1'b1;
    sel_hit   = 1'b0;
    unique case (sel_i)
      4'b0011: sel_hit = word_eq & ~hw_hi;
      4'b1100: sel_hit = word_eq &  hw_hi;
      4'b1111: sel_hit = word_eq & ~hw_hi;
      default: sel_legal = 1'b0;
    endcase
  end

  always_comb begin
    cond_o = 1'b0;
    if (kind_i == K_ADDR)
      cond_o = sel_legal & sel_hit;
    else if (kind_i == K_MISS)
      cond_o = (sel_i == 4'b0000) | (sel_legal & ~sel_hit);
  end
endmodule

// File: rtl/ibu_ctx_cmp.sv
module ibu_ctx_cmp
  import ibu_pkg::*;
(
  input  kind_e              kind_i,
  input  logic [VAL_W-1:0]   val_i,
  input  logic [CTX_W-1:0]   ctx1_i,
  input  logic [CTX_W-1:0]   ctx2_i,
  input  logic [VMID_W-1:0]  vmid_i,
  output logic               match_o
);
  logic c1_eq, c2_eq, vm_eq;

  assign c1_eq = val_i[CTX_W-1:0] == ctx1_i;
  assign c2_eq = val_i[VAL_W-1:CTX_W] == ctx2_i;
  assign vm_eq = val_i[CTX_W+VMID_W-1:CTX_W] == vmid_i;

  always_comb begin
    unique case (kind_i)
      K_CTX, K_CTX1: match_o = c1_eq;
      K_VMID:        match_o = vm_eq;
      K_VMCTX:       match_o = vm_eq & c1_eq;
      K_CTX2:        match_o = c2_eq;
      K_FULL:        match_o = c1_eq & c2_eq;
      default:       match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/insn_bkpt_unit.sv
module insn_bkpt_unit
  import ibu_pkg::*;
#(
  parameter int NUM_BKPT = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BKPT*CW_W-1:0]  ctrl_i,
  input  logic [NUM_BKPT*VAL_W-1:0] value_i,
  input  logic                      fetch_valid_i,
  input  logic [VAL_W-1:0]          fetch_addr_i,
  input  logic [CTX_W-1:0]          ctx1_i,
  input  logic [CTX_W-1:0]          ctx2_i,
  input  logic [VMID_W-1:0]         vmid_i,
  output logic [NUM_BKPT-1:0]       hit_o
);
  bctl_t                 ctl      [NUM_BKPT];
  logic [NUM_BKPT-1:0]   addr_ok;
  logic [NUM_BKPT-1:0]   ctx_m;
  logic [NUM_BKPT-1:0]   ctx_ok;
  logic [LINK_SPAN-1:0]  ctx_ok_pad;
  logic [NUM_BKPT-1:0]   raw_hit;
  logic [NUM_BKPT-1:0]   hit_q;

  for (genvar i = 0; i < NUM_BKPT; i++) begin : g_bp
    assign ctl[i] = decode_ctl(ctrl_i[i*CW_W +: CW_W]);

    ibu_addr_cmp #(.AW(VAL_W)) u_addr (
      .kind_i  (ctl[i].kind),
      .sel_i   (ctl[i].sel),
      .val_i   (value_i[i*VAL_W +: VAL_W]),
      .fetch_i (fetch_addr_i),
      .cond_o  (addr_ok[i])
    );

    ibu_ctx_cmp u_ctx (
      .kind_i  (ctl[i].kind),
      .val_i   (value_i[i*VAL_W +: VAL_W]),
      .ctx1_i  (ctx1_i),
      .ctx2_i  (ctx2_i),
      .vmid_i  (vmid_i),
      .match_o (ctx_m[i])
    );

    // usable as link target: enabled context kind that matches now
    assign ctx_ok[i] = ctl[i].en & ~is_addr_kind(ctl[i].kind) & ctx_m[i];
  end

  assign ctx_ok_pad = LINK_SPAN'(ctx_ok);

  always_comb begin
    for (int i = 0; i < NUM_BKPT; i++) begin
      raw_hit[i] = 1'b0;
      if (ctl[i].en) begin
        if (is_addr_kind(ctl[i].kind))
          raw_hit[i] = addr_ok[i] & (~ctl[i].linked | ctx_ok_pad[ctl[i].lbn]);
        else
          raw_hit[i] = ~ctl[i].linked & ctx_m[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hit_q <= '0;
    else if (fetch_valid_i) hit_q <= raw_hit;
    else                    hit_q <= '0;
  end

  assign hit_o = hit_q;

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> hit_o == '0);

  for (genvar i = 0; i < NUM_BKPT; i++) begin : g_chk
    a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl[i].en |=> !hit_o[i]);

    a_r5_miss_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_valid_i && ctl[i].en && ctl[i].kind == K_MISS && ctl[i].sel == 4'b0000
       && !ctl[i].linked) |=> hit_o[i]);

    a_r6_bad_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl[i].kind == K_ADDR && !(ctl[i].sel inside {4'b0011, 4'b1100, 4'b1111}))
      |=> !hit_o[i]);

    a_r8_linked_ctx_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!is_addr_kind(ctl[i].kind) && ctl[i].linked) |=> !hit_o[i]);

    a_r10_link_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_addr_kind(ctl[i].kind) && ctl[i].linked
       && {1'b0, ctl[i].lbn} >= (LBN_W+1)'(NUM_BKPT)) |=> !hit_o[i]);

    a_r9_link_needs_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_addr_kind(ctl[i].kind) && ctl[i].linked && !ctx_ok_pad[ctl[i].lbn])
      |=> !hit_o[i]);
  end
endmodule

// File: tb/insn_bkpt_unit_test.sv
module insn_bkpt_unit_test;
  localparam int NB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*32-1:0] ctrl_flat = '0;
  logic [NB*64-1:0] val_flat = '0;
  logic        vld = 1'b0;
  logic [63:0] fa = '0;
  logic [31:0] c1 = '0, c2 = '0;
  logic [15:0] vm = '0;
  logic [NB-1:0] hit;

  logic [31:0] ctl [NB];
  logic [63:0] val [NB];
  logic [NB-1:0] exp_q [$];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  insn_bkpt_unit #(.NUM_BKPT(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl_flat), .value_i(val_flat),
    .fetch_valid_i(vld), .fetch_addr_i(fa), .ctx1_i(c1), .ctx2_i(c2),
    .vmid_i(vm), .hit_o(hit)
  );

  function automatic logic [31:0] mk(bit en, int kind, bit lk, int sel, int lbn);
    logic [31:0] w = '0;
    w[0] = en; w[8:5] = sel[3:0]; w[19:16] = lbn[3:0];
    w[20] = lk; w[23:21] = kind[2:0];
    return w;
  endfunction

  function automatic bit ctx_eq(int j, int k);
    bit a = val[j][31:0] == c1;
    bit b = val[j][63:32] == c2;
    bit v = val[j][47:32] == vm;
    case (k)
      1, 3: return a;
      4: return v;
      5: return a && v;
      6: return b;
      7: return a && b;
      default: return 0;
    endcase
  endfunction

  function automatic bit target_ok(int j);
    int k;
    if (j >= NB) return 0;
    if (!ctl[j][0]) return 0;
    k = int'(ctl[j][23:21]);
    if (k == 0 || k == 2) return 0;
    return ctx_eq(j, k);
  endfunction

  function automatic logic [NB-1:0] model();
    logic [NB-1:0] r = '0;
    if (!vld) return r;
    for (int i = 0; i < NB; i++) begin
      int k = int'(ctl[i][23:21]);
      bit lk = ctl[i][20];
      int sel = int'(ctl[i][8:5]);
      bit same = (fa >> 2) == (val[i] >> 2);
      bit h = fa[1];
      bit legal = (sel == 3) || (sel == 12) || (sel == 15);
      bit pick = (sel == 12) ? (same && h) : (same && !h);
      bit c;
      if (!ctl[i][0]) continue;
      if (k != 0 && k != 2) begin
        r[i] = !lk && ctx_eq(i, k);
        continue;
      end
      if (k == 0) c = legal && pick;
      else        c = (sel == 0) || (legal && !pick);
      if (lk) c = c && target_ok(int'(ctl[i][19:16]));
      r[i] = c;
    end
    return r;
  endfunction

  task automatic step(string tag);
    logic [NB-1:0] e;
    for (int i = 0; i < NB; i++) begin
      ctrl_flat[i*32 +: 32] = ctl[i];
      val_flat[i*64 +: 64]  = val[i];
    end
    exp_q.push_back(model());
    @(posedge clk);
    @(negedge clk);
    e = exp_q.pop_front();
    checks++;
    if (hit !== e) begin
      failures++;
      $display("FAIL %s: hit_o actual=%h expected=%h", tag, hit, e);
    end
  endtask

  task automatic fetch(logic [63:0] a, string tag);
    vld = 1'b1; fa = a;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin ctl[i] = '0; val[i] = '0; end
    // R1: reset holds zero despite active stimulus
    vld = 1'b1; fa = 64'h40;
    ctl[4] = mk(1, 2, 0, 0, 0);
    for (int i = 0; i < NB; i++) ctrl_flat[i*32 +: 32] = ctl[i];
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== '0) begin
      failures++;
      $display("FAIL R1: hit_o actual=%h expected=0 in reset", hit);
    end
    rst_n = 1'b1;
    vld = 1'b0;
    step("R1");
    step("R1");

    // R4 address equal
    ctl[0] = mk(1, 0, 0, 15, 0); val[0] = 64'h1_0000_0040;
    ctl[1] = mk(1, 0, 0, 3, 0);  val[1] = 64'h2000;
    ctl[2] = mk(1, 0, 0, 12, 0); val[2] = 64'h2003;
    fetch(64'h1_0000_0040, "R4");
    fetch(64'h1_0000_0041, "R4");
    fetch(64'h1_0000_0042, "R4");
    fetch(64'h0_0000_0040, "R4");
    fetch(64'h2000, "R4");
    fetch(64'h2002, "R4");
    fetch(64'h2004, "R4");
    // R5 mismatch
    ctl[3] = mk(1, 2, 0, 15, 0); val[3] = 64'h3000;
    fetch(64'h3000, "R5");
    fetch(64'h3002, "R5");
    fetch(64'h9000, "R5");
    ctl[3] = mk(1, 2, 0, 12, 0);
    fetch(64'h3002, "R5");
    fetch(64'h3000, "R5");
    // R6 unlisted selects
    ctl[5] = mk(1, 0, 0, 5, 0);  val[5] = 64'h2000;
    ctl[6] = mk(1, 2, 0, 6, 0);  val[6] = 64'h2000;
    fetch(64'h2000, "R6");
    fetch(64'h2002, "R6");
    // R1 valid low
    vld = 1'b0; step("R1");
    // R7 context kinds
    c1 = 32'hABCD; c2 = 32'h22; vm = 16'h7;
    ctl[7] = mk(1, 1, 0, 9, 0); val[7] = 64'h0000_0000_0000_ABCD;
    fetch(64'h8, "R7");
    c1 = 32'hABCE; fetch(64'h8, "R7");
    ctl[7] = mk(1, 4, 0, 0, 0); val[7] = 64'h0000_0007_0000_0000;
    fetch(64'h8, "R7");
    ctl[7] = mk(1, 5, 0, 0, 0); val[7] = 64'h0000_0007_0000_ABCE;
    fetch(64'h8, "R7");
    vm = 16'h8; fetch(64'h8, "R7");
    ctl[7] = mk(1, 6, 0, 0, 0); val[7] = 64'h0000_0022_0000_0000;
    fetch(64'h8, "R7");
    // R8/R9 linking
    c1 = 32'h11; c2 = 32'h22;
    ctl[8] = mk(1, 7, 1, 5, 0); val[8] = 64'h0000_0022_0000_0011;
    ctl[9] = mk(1, 0, 1, 15, 8); val[9] = 64'h5000;
    fetch(64'h5000, "R9");
    fetch(64'h5004, "R8");
    c2 = 32'h23; fetch(64'h5000, "R9");
    c2 = 32'h22;
    ctl[8][0] = 1'b0; fetch(64'h5000, "R10");
    ctl[8][0] = 1'b1;
    // R10 bad link targets
    ctl[10] = mk(1, 0, 1, 15, 13); val[10] = 64'h5000;
    ctl[11] = mk(1, 0, 1, 15, 0);  val[11] = 64'h5000;
    fetch(64'h5000, "R10");
    // R2 disable
    for (int i = 0; i < NB; i++) ctl[i][0] = 1'b0;
    fetch(64'h5000, "R2");
    fetch(64'h1_0000_0040, "R2");
    // R3 random phase, reserved bits random too
    for (int n = 0; n < 400; n++) begin
      logic [63:0] pool [4] = '{64'h1000, 64'h1002, 64'h2000, 64'h2006};
      if (n % 8 == 0)
        for (int i = 0; i < NB; i++) begin
          ctl[i] = $urandom();
          ctl[i][8:5] = ($urandom_range(0, 3) == 0) ? 4'($urandom()) :
                        (($urandom_range(0, 1) == 0) ? 4'b1111 : 4'b0011);
          val[i] = {16'h0, 16'($urandom_range(0, 1)), 32'($urandom_range(0, 1))};
          val[i][15:0] = 16'(pool[$urandom_range(0, 3)]) ^ 16'($urandom_range(0, 1));
        end
      vld = ($urandom_range(0, 7) != 0);
      fa = pool[$urandom_range(0, 3)];
      c1 = 32'($urandom_range(0, 1)) ^ 32'(pool[$urandom_range(0, 3)][15:0]);
      c2 = 32'($urandom_range(0, 1));
      vm = 16'($urandom_range(0, 1));
      step("R3");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule